// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into a programmable target device over a passive serial link. A start pulse and a byte count begin a load. The block pulls the active-low configuration request line and holds it. It checks that the device answers on its active-low status line, releases the request, and then waits for the device to release status. If the device does not release status in time, the load aborts.

Bitstream bytes then arrive on a byte-wide valid/ready stream. Each byte is shifted out least significant bit first. For every bit the block lowers the serial clock, then presents the data bit, then raises the clock, so the device samples on the rising edge. After the last byte the block requires the device's configuration-done input to be high. It then sends a fixed run of trailing clock pulses and reports success.

Every wait is set by a parameter in system clock cycles: the request hold time, the settle time, the status timeout and the per-step delay. Any failure leaves the pins idle and reports a two-bit error code.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, the outputs are at rest: `cfg_req_n_o`=1, `dclk_o`=0, `dout_o`=0, `busy_o`=0, `s_ready_o`=0, `success_o`=0, `err_o`=0 and `err_code_o`=0.
- R2: A start pulse in idle drives `cfg_req_n_o` low for at least HOLD_US*CYC_PER_US cycles, with the serial clock low. If `status_n_i` is not 0 at the end of the hold, the load ends with error code 1 (no reset response) and no clock edges.
- R3: After the request is released, the block waits SETTLE_US*CYC_PER_US cycles and then polls for `status_n_i`=1. If status stays 0 for TIMEOUT_MS*CYC_PER_US*1000 further cycles, the load ends with error code 2 (timeout). The error comes no earlier than settle plus timeout cycles after release.
- R4: Exactly `byte_cnt_i` bytes are sent. Each byte takes 8 rising edges of `dclk_o`, and the first edge carries bit 0.
- R5: The data bit is set up while the clock is low. `dout_o` is unchanged for at least STEP_CYC+1 cycles before each rising clock edge. Every clock high and low phase lasts at least STEP_CYC+1 cycles.
- R6: `s_ready_o` is high only while the block waits for a byte with bytes still owed. While no byte is valid, the clock is held low and no edges occur. Gaps in `s_valid_i` do not change the bytes received.
- R7: After the last byte, if `done_i` is 0 the load ends with error code 3 (done missing). A load with a byte count of zero ends the same way, with no data edges.
- R8: With `done_i`=1 after the last byte, the block emits exactly 12 more rising clock edges with `dout_o`=0, then raises `success_o`.
- R9: When a load ends, the pins return to rest and `busy_o` falls. Exactly one of `success_o` and `err_o` is set, and it stays set until the next accepted start, which clears both and the error code.
- R10: A start pulse while `busy_o` is high is ignored. The load in progress sends its original byte count and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (accepted only when idle) |
| byte_cnt_i | input | CNT_W | Number of bytes to send, sampled with the start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| cfg_req_n_o | output | 1 | Configuration request to device, active low |
| dclk_o | output | 1 | Serial configuration clock |
| dout_o | output | 1 | Serial configuration data |
| status_n_i | input | 1 | Device status, active low |
| done_i | input | 1 | Device configuration done |
| busy_o | output | 1 | A load is in progress |
| success_o | output | 1 | Last load completed successfully (sticky) |
| err_o | output | 1 | Last load aborted (sticky) |
| err_code_o | output | 2 | 0 none, 1 no reset response, 2 status timeout, 3 done missing |

## Verification
The status timeout is the hardest case to reach: the device has to answer the request correctly and then never release status. The bench's device model has a stuck mode for this. The timeout is scaled down to a few thousand cycles so that the full window can elapse, and the bench measures the distance from request release to the error. A start pulse in mid-load is placed by the stream driver right after the second byte is accepted, with a different byte count on the bus. A device that never raises done exercises the done check after a full data phase.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETTLE,
        ST_POLL,
        ST_FETCH,
        ST_BLO,
        ST_BDAT,
        ST_BHI,
        ST_CHK,
        ST_THI,
        ST_TLO
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NORESP  = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_NODONE  = 2'd3
    } ld_err_e;

    typedef struct packed {
        logic req_n;
        logic dclk;
        logic dout;
    } pin_t;

    localparam int unsigned TRAIL_PULSES = 12;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels as a function of state and the current shift bit.
    function automatic pin_t pins_for(input ld_state_e st, input logic bitv);
        pin_t p;
        p.req_n = (st != ST_REQ);
        p.dclk  = (st == ST_BHI) || (st == ST_THI);
        p.dout  = ((st == ST_BDAT) || (st == ST_BHI)) ? bitv : 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       shift_i,
    output logic       bit_o,
    output logic       last_o
);
    logic [7:0] sh_q;
    logic [2:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= byte_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {1'b0, sh_q[7:1]};
            idx_q <= idx_q + 3'd1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (idx_q == 3'd7);
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned HOLD_US    = 2,
    parameter int unsigned SETTLE_US  = 2,
    parameter int unsigned TIMEOUT_MS = 100,
    parameter int unsigned STEP_CYC   = 2,
    parameter int unsigned CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    output logic             cfg_req_n_o,
    output logic             dclk_o,
    output logic             dout_o,
    input  logic             status_n_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             success_o,
    output logic             err_o,
    output logic [1:0]       err_code_o
);
    import ps_cfg_pkg::*;

    localparam int unsigned HOLD_CYC    = HOLD_US * CYC_PER_US;
    localparam int unsigned SETTLE_CYC  = SETTLE_US * CYC_PER_US;
    localparam int unsigned TIMEOUT_CYC = TIMEOUT_MS * CYC_PER_US * 1000;
    localparam int unsigned TMR_MAX     = max2(max2(HOLD_CYC, SETTLE_CYC), max2(TIMEOUT_CYC, STEP_CYC));
    localparam int unsigned TMR_W       = $clog2(TMR_MAX + 1);
    localparam int unsigned TR_W        = $clog2(TRAIL_PULSES + 1);

    ld_state_e        st_q, st_d;
    logic [CNT_W-1:0] rem_q;
    logic [TR_W-1:0]  trail_q;
    logic             ok_q, err_q;
    ld_err_e          code_q, code_d;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_bit, sh_last;
    logic             accept, trail_load, trail_dec, set_ok, set_err;
    pin_t             pins;

    ps_cfg_timer #(.W(TMR_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    ps_cfg_shifter i_shifter (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sh_load),
        .byte_i  (s_data_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    // Sequencer next-state logic
    always_comb begin
        st_d       = st_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        sh_shift   = 1'b0;
        trail_load = 1'b0;
        trail_dec  = 1'b0;
        set_ok     = 1'b0;
        set_err    = 1'b0;
        code_d     = ERR_NONE;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d     = ST_REQ;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HOLD_CYC);
                end
            end
            ST_REQ: begin
                if (tmr_zero) begin
                    if (!status_n_i) begin
                        st_d     = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(SETTLE_CYC);
                    end else begin
                        st_d    = ST_IDLE;
                        set_err = 1'b1;
                        code_d  = ERR_NORESP;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    st_d     = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TIMEOUT_CYC);
                end
            end
            ST_POLL: begin
                if (status_n_i) begin
                    st_d = ST_FETCH;
                end else if (tmr_zero) begin
                    st_d    = ST_IDLE;
                    set_err = 1'b1;
                    code_d  = ERR_TIMEOUT;
                end
            end
            ST_FETCH: begin
                if (rem_q == '0) begin
                    st_d     = ST_CHK;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STEP_CYC);
                end else if (s_valid_i) begin
                    accept   = 1'b1;
                    st_d     = ST_BLO;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STEP_CYC);
                end
            end
            ST_BLO: begin
                if (tmr_zero) begin
                    st_d     = ST_BDAT;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STEP_CYC);
                end
            end
            ST_BDAT: begin
                if (tmr_zero) begin
                    st_d     = ST_BHI;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STEP_CYC);
                end
            end
            ST_BHI: begin
                if (tmr_zero) begin
                    sh_shift = 1'b1;
                    if (sh_last) begin
                        st_d = ST_FETCH;
                    end else begin
                        st_d     = ST_BLO;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(STEP_CYC);
                    end
                end
            end
            ST_CHK: begin
                if (tmr_zero) begin
                    if (done_i) begin
                        st_d       = ST_THI;
                        trail_load = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TMR_W'(STEP_CYC);
                    end else begin
                        st_d    = ST_IDLE;
                        set_err = 1'b1;
                        code_d  = ERR_NODONE;
                    end
                end
            end
            ST_THI: begin
                if (tmr_zero) begin
                    st_d     = ST_TLO;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STEP_CYC);
                end
            end
            ST_TLO: begin
                if (tmr_zero) begin
                    trail_dec = 1'b1;
                    if (trail_q == TR_W'(1)) begin
                        st_d   = ST_IDLE;
                        set_ok = 1'b1;
                    end else begin
                        st_d     = ST_THI;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(STEP_CYC);
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign sh_load = accept;

    // State, byte budget, trailing-pulse count and result flags
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            rem_q   <= '0;
            trail_q <= '0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start_i) begin
                rem_q  <= byte_cnt_i;
                ok_q   <= 1'b0;
                err_q  <= 1'b0;
                code_q <= ERR_NONE;
            end else if (accept) begin
                rem_q <= rem_q - 1'b1;
            end
            if (trail_load)
                trail_q <= TR_W'(TRAIL_PULSES);
            else if (trail_dec)
                trail_q <= trail_q - 1'b1;
            if (set_ok)
                ok_q <= 1'b1;
            if (set_err) begin
                err_q  <= 1'b1;
                code_q <= code_d;
            end
        end
    end

    assign pins        = pins_for(st_q, sh_bit);
    assign cfg_req_n_o = pins.req_n;
    assign dclk_o      = pins.dclk;
    assign dout_o      = pins.dout;
    assign s_ready_o   = (st_q == ST_FETCH) && (rem_q != '0);
    assign busy_o      = (st_q != ST_IDLE);
    assign success_o   = ok_q;
    assign err_o       = err_q;
    assign err_code_o  = code_q;

endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker #(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned HOLD_US    = 2,
    parameter int unsigned STEP_CYC   = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       s_ready_o,
    input logic       cfg_req_n_o,
    input logic       dclk_o,
    input logic       dout_o,
    input logic       busy_o,
    input logic       success_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);
    localparam int unsigned HOLD_CYC = HOLD_US * CYC_PER_US;

    int unsigned low_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= 0;
            hi_cnt  <= 0;
        end else begin
            low_cnt <= cfg_req_n_o ? 0 : low_cnt + 1;
            hi_cnt  <= dclk_o ? hi_cnt + 1 : 0;
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cfg_req_n_o && !dclk_o && !dout_o)); // R9
    AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !s_ready_o); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req_n_o) |-> (low_cnt >= HOLD_CYC)); // R2
    AST_REQ_CLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_req_n_o |-> !dclk_o); // R2
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_o) |-> $stable(dout_o)); // R5
    AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk_o) |-> (hi_cnt >= STEP_CYC + 1)); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (success_o != err_o)); // R9
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (err_code_o != 2'd0)); // R9
endmodule

bind ps_cfg_loader ps_cfg_checker #(
    .CYC_PER_US (CYC_PER_US),
    .HOLD_US    (HOLD_US),
    .STEP_CYC   (STEP_CYC)
) i_ps_cfg_checker (
    .clk         (clk),
    .rst         (rst),
    .s_ready_o   (s_ready_o),
    .cfg_req_n_o (cfg_req_n_o),
    .dclk_o      (dclk_o),
    .dout_o      (dout_o),
    .busy_o      (busy_o),
    .success_o   (success_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/test_ps_cfg_loader.sv
module test_ps_cfg_loader;
    localparam int US    = 4;
    localparam int HOLD  = 2 * US;
    localparam int SETL  = 2 * US;
    localparam int TMO   = 1 * US * 1000;
    localparam int STEP  = 1;
    localparam int RESP  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] cnt = '0;
    logic s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic status_n = 1'b1;
    logic done_in = 1'b0;
    logic s_ready, req_n, dclk, dout, busy, ok, err;
    logic [1:0] code;

    ps_cfg_loader #(
        .CYC_PER_US(US), .HOLD_US(2), .SETTLE_US(2), .TIMEOUT_MS(1),
        .STEP_CYC(STEP), .CNT_W(8)
    ) i_ps_cfg_loader (
        .clk(clk), .rst(rst), .start_i(start), .byte_cnt_i(cnt),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
        .cfg_req_n_o(req_n), .dclk_o(dclk), .dout_o(dout),
        .status_n_i(status_n), .done_i(done_in), .busy_o(busy),
        .success_o(ok), .err_o(err), .err_code_o(code)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    task automatic check(input bit cond, input string req, input int act, input int expv);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Device model: 0 normal, 1 no response, 2 status stuck, 3 done never
    int mode = 0, exp_n = 0;
    int rx_bits = 0, rx_n = 0, trail = 0, rel_cnt = 0, since_rel = 0, at_end = 0;
    int hi_len = 0, lo_len = 0, min_hi = 999, min_lo = 999, setup_bad = 0, req_low = 0, last_req_low = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] rx_mem [0:15];
    logic prev_dclk = 1'b0, prev_dout = 1'b0, prev_busy = 1'b0, prev_req = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!req_n) begin
                status_n = (mode == 1) ? 1'b1 : 1'b0;
                done_in = 1'b0; rx_bits = 0; rx_n = 0; trail = 0; rel_cnt = 0;
                since_rel = 0; min_hi = 999; min_lo = 999; setup_bad = 0;
                req_low++;
            end else begin
                if (!prev_req) last_req_low = req_low;
                req_low = 0;
                since_rel++;
                if (!status_n) begin
                    rel_cnt++;
                    if (rel_cnt >= RESP && mode != 2) status_n = 1'b1;
                end
            end
            if (dclk && !prev_dclk) begin
                if (dout !== prev_dout) setup_bad++;
                if (lo_len < min_lo) min_lo = lo_len;
                if (!done_in) begin
                    rx_sh = {dout, rx_sh[7:1]};
                    rx_bits++;
                    if (rx_bits % 8 == 0) begin
                        if (rx_n < 16) rx_mem[rx_n] = rx_sh;
                        rx_n++;
                    end
                    if (rx_bits == exp_n * 8 && mode != 3) done_in = 1'b1;
                end else begin
                    trail++;
                    if (dout) setup_bad++;
                end
                lo_len = 0;
            end
            if (!dclk && prev_dclk) begin
                if (hi_len < min_hi) min_hi = hi_len;
                hi_len = 0;
            end
            if (dclk) hi_len++; else lo_len++;
            if (prev_busy && !busy) at_end = since_rel;
            prev_dclk = dclk; prev_dout = dout; prev_busy = busy; prev_req = req_n;
        end
    end

    function automatic logic [7:0] pat(input int p, input int i);
        case (p)
            0: pat = 8'((i * 37 + 5) & 255);
            1: pat = i[0] ? 8'h80 : 8'h01;
            2: pat = 8'(~(i * 53 + 1));
            default: pat = i[0] ? 8'hFF : 8'h00;
        endcase
    endfunction

    logic [7:0] tx [0:15];

    task automatic run_load(input int n, input int p, input int gap, input bit poke);
        int i = 0, gc = 0;
        bit poked = 0;
        for (int k = 0; k < n; k++) tx[k] = pat(p, k);
        exp_n = n;
        @(negedge clk); start = 1'b1; cnt = 8'(n);
        @(negedge clk); start = 1'b0;
        while (i < n) begin
            @(negedge clk);
            start = 1'b0;
            if (!busy) break;
            if (gc > 0) begin
                s_valid = 1'b0; gc--;
            end else begin
                s_valid = 1'b1; s_data = tx[i];
                if (s_ready) begin
                    i++; gc = gap;
                    if (poke && i == 2 && !poked) begin
                        poked = 1; start = 1'b1; cnt = 8'd1;
                    end
                end
            end
        end
        @(negedge clk); s_valid = 1'b0; start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_rest(input string req);
        check(req_n && !dclk && !dout && !busy && !s_ready, req, {req_n, dclk, dout, busy, s_ready}, 5'b10000);
    endtask

    task automatic check_good(input int n, input string tag);
        check(ok && !err && code == 2'd0, {tag, " R9 success flags"}, {ok, err, code}, 4'b1000);
        check(rx_n == n, {tag, " R4 byte count"}, rx_n, n);
        for (int k = 0; k < n && k < 16; k++)
            check(rx_mem[k] == tx[k], {tag, " R4 byte LSB-first"}, rx_mem[k], tx[k]);
        check(trail == 12, {tag, " R8 trailing edges"}, trail, 12);
        check(setup_bad == 0, {tag, " R5 data setup"}, setup_bad, 0);
        check(min_hi >= STEP + 1 && min_lo >= STEP + 1, {tag, " R5 pulse widths"}, (min_hi < min_lo) ? min_hi : min_lo, STEP + 1);
        check(last_req_low >= HOLD, {tag, " R2 request hold"}, last_req_low, HOLD);
        check_rest({tag, " R9 pins at rest"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_rest("R1 reset pins");
        check(!ok && !err && code == 2'd0, "R1 reset flags", {ok, err, code}, 0);

        // Sweep: counts, patterns, stream gaps
        for (int n = 1; n <= 4; n++)
            for (int p = 0; p < 4; p++)
                for (int g = 0; g < 3; g++) begin
                    mode = 0;
                    run_load(n, p, g, 1'b0);
                    check_good(n, (g != 0) ? "R6 gapped" : "R4 sweep");
                end

        // No reset response
        mode = 1;
        run_load(2, 0, 0, 1'b0);
        check(err && !ok && code == 2'd1, "R2 no response code", {err, ok, code}, 4'b1001);
        check(rx_bits == 0, "R2 no clock edges", rx_bits, 0);
        check_rest("R9 rest after R2 error");

        // Status never released
        mode = 2;
        run_load(2, 0, 0, 1'b0);
        check(err && code == 2'd2, "R3 timeout code", code, 2);
        check(at_end >= SETL + TMO, "R3 timeout window", at_end, SETL + TMO);
        check(rx_bits == 0, "R3 no data edges", rx_bits, 0);

        // Done never asserted
        mode = 3;
        run_load(3, 2, 1, 1'b0);
        check(err && code == 2'd3, "R7 done missing code", code, 3);
        check(rx_n == 3 && trail == 0, "R7 data sent no trail", rx_n * 100 + trail, 300);

        // Zero byte count
        mode = 0;
        run_load(0, 0, 0, 1'b0);
        check(err && code == 2'd3 && rx_bits == 0, "R7 zero count", code * 100 + rx_bits, 300);

        // Recovery after error clears flags; start while busy ignored
        mode = 0;
        run_load(5, 0, 1, 1'b1);
        check_good(5, "R10 start while busy");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule